// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits behind the serial front end of a byte-addressed nonvolatile store. While a write-array frame is being received, each data byte lands in a 32-byte page buffer. The in-page offset advances after every byte, and the page number taken from the first byte stays fixed for the whole frame. A per-offset valid mask records which bytes have actually arrived.

When the frame closes cleanly, the block enters a self-timed busy period. This happens only if the chip select released exactly on a byte boundary and the write-enable latch was set when the frame began. During the first cycles of the busy period, the buffered bytes go to a one-byte-per-cycle memory write port, one page offset per cycle, in ascending offset order. An offset is skipped if no byte arrived for it or if the protection query reports its address as locked. Busy lasts a parameterised number of clock cycles. The last busy cycle pulses a strobe that clears the write-enable latch.

Opcode decoding, the status register and the storage technology sit outside this block. Protection is asked through a combinational query port: `prot_addr` goes out and `prot_hit` comes back.

Top module: `page_prog_seq`

## Requirements
- R1: The first data byte of a frame (byte_first high) sets the page number to byte_addr[13:5] and the offset to byte_addr[4:0]. Each later byte is stored at the next offset, incremented modulo 32. Every write of the commit carries the page number in bits 13:5.
- R2: A frame of more than 32 bytes wraps the offset, so a later byte replaces the earlier byte held at the same offset.
- R3: If frm_end arrives with frm_aligned low, the frame is discarded: busy stays low and no write happens.
- R4: If wel was low when the frame's first byte arrived, the frame is ignored: busy stays low and no write happens.
- R5: No write is issued for an address where prot_hit is high. Unprotected offsets of the same page are still written.
- R6: busy rises on the clock edge after an accepted frm_end and stays high for exactly TWC_CYC cycles. In busy cycle k (k = 0..31), page offset k is written if it is due.
- R7: wel_clr is high for exactly one cycle, the last busy cycle, once per accepted frame.
- R8: Only offsets that received a byte in the frame are written. A frame end with no bytes since the last commit writes nothing.
- R9: Bytes and frame ends presented while busy is high are ignored.
- R10: After reset, busy, mem_we and wel_clr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A data byte of the write frame has been received |
| byte_first | input | 1 | Marks the first data byte of a frame |
| byte_addr | input | AW | Frame start address, sampled with the first byte |
| byte_data | input | 8 | Received data byte |
| frm_end | input | 1 | Chip select released, frame ended |
| frm_aligned | input | 1 | The frame ended exactly on a byte boundary |
| wel | input | 1 | Current write-enable latch |
| prot_addr | output | AW | Address being queried for protection |
| prot_hit | input | 1 | The queried address is protected |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Self-timed write cycle in progress |
| wel_clr | output | 1 | Pulse that clears the write-enable latch |

## Verification
The bench targets several corner cases, each of which shows up as a specific wrong behaviour:
- A frame that starts mid-page and carries more than 32 bytes. A design that carried the offset into the page number would write into the next page. A design that kept the first copy of a byte would commit stale data.
- Frames that end off a byte boundary, and frames that start with the latch clear. A faulty design would start a busy period for them.
- A page that straddles a protection boundary. A faulty design would either write locked bytes or drop the unlocked ones.
- Bytes and a second frame sent during busy, followed by an empty frame end. A design that did not freeze its buffer, or did not clear its valid mask, would issue extra writes.

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
  parameter int AW      = 14,
  parameter int PAGE    = 32,
  parameter int TWC_CYC = 625000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic          byte_first,
  input  logic [AW-1:0] byte_addr,
  input  logic [7:0]    byte_data,
  input  logic          frm_end,
  input  logic          frm_aligned,
  input  logic          wel,
  output logic [AW-1:0] prot_addr,
  input  logic          prot_hit,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          busy,
  output logic          wel_clr
);
  localparam int OW = $clog2(PAGE);
  localparam int CW = $clog2(TWC_CYC + 1);

  logic [AW-OW-1:0] page_q;
  logic [OW-1:0]    off_q;
  logic [PAGE-1:0]  mask_q;
  logic [7:0]       pbuf [PAGE];
  logic             armed_q;
  logic             busy_q;
  logic [CW-1:0]    cnt_q;

  logic [OW-1:0] idx;
  logic          in_commit, last, accept;
  logic [OW-1:0] wr_off;

  assign idx       = cnt_q[OW-1:0];
  assign in_commit = busy_q && (cnt_q < CW'(PAGE));
  assign last      = busy_q && (cnt_q == CW'(TWC_CYC - 1));
  assign accept    = frm_end && frm_aligned && armed_q && (|mask_q);
  assign wr_off    = byte_first ? byte_addr[OW-1:0] : off_q;

  assign prot_addr = {page_q, idx};
  assign mem_addr  = {page_q, idx};
  assign mem_wdata = pbuf[idx];
  assign mem_we    = in_commit && mask_q[idx] && !prot_hit;
  assign busy      = busy_q;
  assign wel_clr   = last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      off_q   <= '0;
      mask_q  <= '0;
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) begin
        busy_q  <= 1'b0;
        cnt_q   <= '0;
        mask_q  <= '0;
        armed_q <= 1'b0;
      end
    end else if (byte_vld) begin
      off_q <= wr_off + 1'b1;
      if (byte_first) begin
        page_q  <= byte_addr[AW-1:OW];
        armed_q <= wel;
        mask_q  <= PAGE'(1) << byte_addr[OW-1:0];
      end else begin
        mask_q[off_q] <= 1'b1;
      end
    end else if (frm_end) begin
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        mask_q  <= '0;
        armed_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!busy_q && byte_vld) pbuf[wr_off] <= byte_data;
  end

  assert_no_prot_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !prot_hit);

  assert_write_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_clr_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy);

  assert_start_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frm_end && frm_aligned));

  assert_start_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed_q));

  assert_page_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[AW-1:OW]));

  assert_single_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> busy);
endmodule

// File: tb/page_prog_seq_bench.sv
module page_prog_seq_bench;
  localparam int AW  = 14;
  localparam int TWC = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 0, byte_first = 0, frm_end = 0, frm_aligned = 0, wel = 0;
  logic [AW-1:0] byte_addr = '0;
  logic [7:0] byte_data = '0;
  logic [AW-1:0] prot_addr, mem_addr;
  logic prot_hit, mem_we, busy, wel_clr;
  logic [7:0] mem_wdata;
  int prot_lo = 1 << AW;

  always #4 clk = ~clk;
  assign prot_hit = int'(prot_addr) >= prot_lo;

  page_prog_seq #(.AW(AW), .PAGE(32), .TWC_CYC(TWC)) u_page_prog_seq (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_first(byte_first),
    .byte_addr(byte_addr), .byte_data(byte_data), .frm_end(frm_end),
    .frm_aligned(frm_aligned), .wel(wel), .prot_addr(prot_addr), .prot_hit(prot_hit),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .wel_clr(wel_clr));

  int checks = 0, errors = 0;
  string cur = "R10";
  int wr_cnt = 0, busy_cyc = 0, clr_cnt = 0;
  int wr_addr_q[$];
  int wr_data_q[$];

  // behavioural reference
  int m_left = 0, m_cyc = 0, m_base = 0, m_off = 0;
  bit m_ok = 0;
  bit m_mask[32];
  int m_buf[32];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_cyc = 0; m_ok = 0;
      foreach (m_mask[i]) m_mask[i] = 0;
    end else if (m_left > 0) begin
      m_left--; m_cyc++;
      if (m_left == 0) begin
        foreach (m_mask[i]) m_mask[i] = 0;
        m_ok = 0;
      end
    end else if (byte_vld) begin
      if (byte_first) begin
        m_base = int'(byte_addr) / 32; m_off = int'(byte_addr) % 32; m_ok = wel;
        foreach (m_mask[i]) m_mask[i] = 0;
      end
      m_buf[m_off] = byte_data; m_mask[m_off] = 1; m_off = (m_off + 1) % 32;
    end else if (frm_end) begin
      int any = 0;
      foreach (m_mask[i]) any += m_mask[i];
      if (frm_aligned && m_ok && any > 0) begin
        m_left = TWC; m_cyc = 0;
      end else begin
        foreach (m_mask[i]) m_mask[i] = 0;
        m_ok = 0;
      end
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit eb, ew, ec;
    int ea;
    eb = m_left > 0;
    ea = m_base * 32 + (m_cyc % 32);
    ew = eb && m_cyc < 32 && m_mask[m_cyc % 32] && !(ea >= prot_lo);
    ec = m_left == 1;
    check(busy == eb, "busy", busy, eb);
    check(wel_clr == ec, "wel_clr", wel_clr, ec);
    check(mem_we == ew, "mem_we", mem_we, ew);
    if (ew && mem_we) begin
      check(int'(mem_addr) == ea, "mem_addr", mem_addr, ea);
      check(int'(mem_wdata) == m_buf[m_cyc % 32], "mem_wdata", mem_wdata, m_buf[m_cyc % 32]);
    end
    if (mem_we) begin wr_cnt++; wr_addr_q.push_back(mem_addr); wr_data_q.push_back(mem_wdata); end
    if (busy) busy_cyc++;
    if (wel_clr) clr_cnt++;
  end

  task automatic clear_counts();
    wr_cnt = 0; busy_cyc = 0; clr_cnt = 0;
    wr_addr_q.delete(); wr_data_q.delete();
  endtask

  task automatic send(int addr, int n, bit w, bit al, int d0);
    wel = w;
    for (int k = 0; k < n; k++) begin
      byte_vld = 1; byte_first = (k == 0); byte_addr = AW'(addr); byte_data = 8'(d0 + k);
      @(negedge clk);
      byte_vld = 0; byte_first = 0;
      @(negedge clk);
    end
    frm_end = 1; frm_aligned = al;
    @(negedge clk);
    frm_end = 0; frm_aligned = 0;
  endtask

  task automatic settle();
    repeat (TWC + 10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL %s watchdog actual=hung expected=finished", cur);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur = "R10";
    check(busy == 0, "busy after reset", busy, 0);
    check(mem_we == 0, "mem_we after reset", mem_we, 0);
    check(wel_clr == 0, "wel_clr after reset", wel_clr, 0);
    rst_n = 1;
    @(negedge clk);

    cur = "R1"; clear_counts();
    send(14'h1234, 10, 1, 1, 8'h40); settle();
    check(wr_cnt == 10, "write count", wr_cnt, 10);
    check(wr_addr_q.size() > 0 && wr_addr_q[0] == 14'h1234, "first addr", wr_addr_q.size() > 0 ? wr_addr_q[0] : -1, 14'h1234);
    check(busy_cyc == TWC, "R6 busy length", busy_cyc, TWC);
    check(clr_cnt == 1, "R7 wel_clr pulses", clr_cnt, 1);

    cur = "R2"; clear_counts();
    send(14'h0058, 40, 1, 1, 8'h10); settle();
    check(wr_cnt == 32, "write count", wr_cnt, 32);
    check(wr_addr_q.size() == 32 && wr_addr_q[0] == 14'h0040, "offset0 addr", wr_addr_q.size() == 32 ? wr_addr_q[0] : -1, 14'h0040);
    check(wr_data_q.size() == 32 && wr_data_q[24] == 8'h30, "offset24 overwritten", wr_data_q.size() == 32 ? wr_data_q[24] : -1, 8'h30);

    cur = "R3"; clear_counts();
    send(14'h0200, 5, 1, 0, 8'h01); settle();
    check(wr_cnt == 0 && busy_cyc == 0, "unaligned writes", wr_cnt + busy_cyc, 0);

    cur = "R4"; clear_counts();
    send(14'h0300, 5, 0, 1, 8'h02); settle();
    check(wr_cnt == 0 && busy_cyc == 0, "disabled writes", wr_cnt + busy_cyc, 0);

    cur = "R5"; clear_counts(); prot_lo = 14'h3018;
    send(14'h3010, 16, 1, 1, 8'h80); settle();
    check(wr_cnt == 8, "unprotected writes", wr_cnt, 8);
    prot_lo = 1 << AW;

    cur = "R9"; clear_counts();
    send(14'h0400, 3, 1, 1, 8'h20);
    send(14'h0410, 4, 1, 1, 8'hA0);
    settle();
    check(wr_cnt == 3, "writes with busy traffic", wr_cnt, 3);
    check(wr_addr_q.size() == 3 && wr_addr_q[2] == 14'h0402, "last addr", wr_addr_q.size() == 3 ? wr_addr_q[2] : -1, 14'h0402);

    cur = "R8"; clear_counts();
    send(14'h0500, 0, 1, 1, 0); settle();
    check(wr_cnt == 0 && busy_cyc == 0, "empty frame", wr_cnt + busy_cyc, 0);
    send(14'h0507, 2, 1, 1, 8'h55); settle();
    check(wr_cnt == 2, "sparse page writes", wr_cnt, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule